// File: doc/BRIEF.md
# Flash Command Status Register

This block is the status byte of a non-volatile memory command controller, placed on a simple byte-wide register bus. Software starts a command by writing 1 to the command-complete flag. The block accepts that write only when no error flag is pending. On acceptance it drops the flag and sends a one-cycle launch pulse to the controller. The flag rises again when the controller reports that the command has finished, or when the controller reports a violation.

Two error flags are kept here: an access error and a protection violation. Each is set by hardware and cleared by writing 1 to it. The block also holds a copy of the controller's busy line and a 2-bit completion code. It drives a sequence-enable output, which tells the controller whether a new command write sequence may start.

Top module: `nvm_cmd_status`

## Requirements
- R1: After reset the status byte reads 0x80, `launch` is 0 and `seq_en` is 1.
- R2: A write to the status address with bit 7 = 1 is accepted when the command-complete flag is 1 and both error flags are 0. On acceptance, at the next clock edge, the flag reads 0 and `launch` is 1 for exactly one cycle. No other write produces a launch.
- R3: The command-complete flag stays 0 until `ctl_done` is sampled high. It then reads 1 from the next clock. At that edge the completion code (bits 1:0) captures `ctl_err_code`.
- R4: The access-error flag (bit 5) is set by `ctl_illegal` or `ctl_seq_viol`. Writing 1 to bit 5 clears it. Writing 0 to bit 5 has no effect.
- R5: While the access-error flag is set, a write of 1 to bit 7 leaves that flag at 1 and produces no launch.
- R6: The protection-violation flag (bit 4) is set by `ctl_prot_viol` and cleared by writing 1 to bit 4. While it is set, no launch occurs and `seq_en` is 0.
- R7: Bit 3 shows `ctl_busy` as sampled at the previous clock edge. Software writes do not change it.
- R8: Bits 6 and 2 always read 0. A write to an address other than the status address changes nothing. `rdata` is 0 when the status address is not selected.
- R9: If a violation input is sampled while the command-complete flag is 0, the flag reads 1 from the next clock. The matching error flag sets at that same edge.
- R10: When a hardware set and a write-1 clear reach an error flag in the same cycle, the flag stays set.
- R11: An accepted launch clears the completion code to 0. `seq_en` equals 1 exactly when the command-complete flag is 1 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | ADDR_W | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected |
| launch | output | 1 | One-cycle command launch pulse |
| seq_en | output | 1 | Command write sequence may start |
| ctl_busy | input | 1 | Controller busy |
| ctl_done | input | 1 | Controller finished a command |
| ctl_illegal | input | 1 | Illegal command detected |
| ctl_seq_viol | input | 1 | Command write sequence violated |
| ctl_prot_viol | input | 1 | Protected address targeted |
| ctl_err_code | input | 2 | Completion error code, valid with done |

## Verification
Every piece of state in this block shows directly on the status byte one cycle after the event that changes it. A flag stuck high, a lost set or an unwanted clear is therefore visible on the very next read of `rdata`. A fault in the launch gating shows on `launch` and `seq_en` in the cycle after the offending write. A missing or doubled pulse there shows in the pulse-width check at once. The hard cases are collisions between hardware sets and software clears, and attempts to launch while a flag blocks the launch. Each of these is driven in isolation so that a single wrong bit can be traced to its requirement.

// File: rtl/nvm_cmd_status.sv
module nvm_cmd_status #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              launch,
  output logic              seq_en,
  input  logic              ctl_busy,
  input  logic              ctl_done,
  input  logic              ctl_illegal,
  input  logic              ctl_seq_viol,
  input  logic              ctl_prot_viol,
  input  logic [1:0]        ctl_err_code
);

  logic       done_q, acc_q, prot_q, busy_q;
  logic [1:0] code_q;

  wire hit    = reg_sel == STAT_ADDR;
  wire wr_hit = hit && wr_en;
  wire accept = wr_hit && wdata[7] && done_q && !acc_q && !prot_q;
  wire acc_set  = ctl_illegal || ctl_seq_viol;
  wire prot_set = ctl_prot_viol;
  wire finish   = !done_q && (ctl_done || acc_set || prot_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1;
      acc_q  <= 1'b0;
      prot_q <= 1'b0;
      busy_q <= 1'b0;
      code_q <= 2'b00;
      launch <= 1'b0;
    end else begin
      launch <= accept;
      busy_q <= ctl_busy;
      if (accept)      done_q <= 1'b0;
      else if (finish) done_q <= 1'b1;
      if (acc_set)                   acc_q <= 1'b1;
      else if (wr_hit && wdata[5])   acc_q <= 1'b0;
      if (prot_set)                  prot_q <= 1'b1;
      else if (wr_hit && wdata[4])   prot_q <= 1'b0;
      if (accept)                    code_q <= 2'b00;
      else if (!done_q && ctl_done)  code_q <= ctl_err_code;
    end
  end

  assign seq_en = done_q && !acc_q && !prot_q;
  assign rdata  = hit ? {done_q, 1'b0, acc_q, prot_q, busy_q, 1'b0, code_q} : 8'h00;

endmodule

// File: rtl/nvm_cmd_status_chk.sv
module nvm_cmd_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       launch,
  input logic       seq_en,
  input logic [7:0] rdata,
  input logic       done_q,
  input logic       acc_q,
  input logic       prot_q,
  input logic       ctl_illegal,
  input logic       ctl_seq_viol,
  input logic       ctl_prot_viol
);

  AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch); // R2

  AST_LAUNCH_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !done_q && $past(done_q)); // R2

  AST_NO_LAUNCH_ON_ACCERR: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !$past(acc_q)); // R5

  AST_NO_LAUNCH_ON_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !$past(prot_q)); // R6

  AST_PROT_BLOCKS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    prot_q |-> !seq_en); // R6

  AST_ACC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_illegal || ctl_seq_viol) |-> acc_q); // R10

  AST_PROT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_prot_viol) |-> prot_q); // R10

  AST_VIOL_RESTORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!done_q) && $past(ctl_prot_viol)) |-> done_q && prot_q); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6] == 1'b0 && rdata[2] == 1'b0); // R8

endmodule

bind nvm_cmd_status nvm_cmd_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .seq_en(seq_en), .rdata(rdata),
  .done_q(done_q), .acc_q(acc_q), .prot_q(prot_q),
  .ctl_illegal(ctl_illegal), .ctl_seq_viol(ctl_seq_viol), .ctl_prot_viol(ctl_prot_viol)
);

// File: tb/test_nvm_cmd_status.sv
module test_nvm_cmd_status;
  localparam logic [2:0] STAT = 3'd2;
  localparam int NV = 21;
  // {we, wdata, busy, done, illegal, seqviol, protviol, code, exp_rdata, exp_launch, exp_seq}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'h80, 5'b00000, 2'b00, 8'h00, 1'b1, 1'b0}, //  0 R2 launch
    {1'b0, 8'h00, 5'b10000, 2'b00, 8'h08, 1'b0, 1'b0}, //  1 R7 busy
    {1'b1, 8'h80, 5'b10000, 2'b00, 8'h08, 1'b0, 1'b0}, //  2 R3 relaunch ignored
    {1'b0, 8'h00, 5'b11000, 2'b01, 8'h89, 1'b0, 1'b1}, //  3 R3 done
    {1'b0, 8'h00, 5'b00000, 2'b00, 8'h81, 1'b0, 1'b1}, //  4 R7
    {1'b1, 8'h80, 5'b00000, 2'b00, 8'h00, 1'b1, 1'b0}, //  5 R11 code clear
    {1'b0, 8'h00, 5'b00100, 2'b00, 8'hA0, 1'b0, 1'b0}, //  6 R9 illegal
    {1'b1, 8'h80, 5'b00000, 2'b00, 8'hA0, 1'b0, 1'b0}, //  7 R5 blocked
    {1'b1, 8'h5F, 5'b00000, 2'b00, 8'hA0, 1'b0, 1'b0}, //  8 R4 write0
    {1'b1, 8'h20, 5'b00000, 2'b00, 8'h80, 1'b0, 1'b1}, //  9 R4 clear
    {1'b0, 8'h00, 5'b00001, 2'b00, 8'h90, 1'b0, 1'b0}, // 10 R6 set
    {1'b1, 8'h90, 5'b00001, 2'b00, 8'h90, 1'b0, 1'b0}, // 11 R10 prot
    {1'b1, 8'h10, 5'b00000, 2'b00, 8'h80, 1'b0, 1'b1}, // 12 R6 clear
    {1'b0, 8'h00, 5'b00010, 2'b00, 8'hA0, 1'b0, 1'b0}, // 13 R4 seqviol
    {1'b1, 8'h20, 5'b00010, 2'b00, 8'hA0, 1'b0, 1'b0}, // 14 R10 acc
    {1'b1, 8'h20, 5'b00000, 2'b00, 8'h80, 1'b0, 1'b1}, // 15 R4
    {1'b1, 8'hFF, 5'b00000, 2'b00, 8'h00, 1'b1, 1'b0}, // 16 R8 all ones
    {1'b0, 8'h00, 5'b01000, 2'b11, 8'h83, 1'b0, 1'b1}, // 17 R3 code
    {1'b1, 8'h80, 5'b00000, 2'b00, 8'h00, 1'b1, 1'b0}, // 18 R11
    {1'b0, 8'h00, 5'b00001, 2'b00, 8'h90, 1'b0, 1'b0}, // 19 R9 prot
    {1'b1, 8'h10, 5'b00000, 2'b00, 8'h80, 1'b0, 1'b1}  // 20 R6
  };
  localparam string TAG [NV] = '{"R2","R7","R3","R3","R7","R11","R9","R5","R4","R4",
    "R6","R10","R6","R4","R10","R4","R8","R3","R11","R9","R6"};

  logic clk = 0, rst_n = 0, wr_en = 0, launch, seq_en;
  logic [2:0] reg_sel = STAT;
  logic [7:0] wdata = 0, rdata;
  logic busy = 0, done = 0, ill = 0, seqv = 0, prot = 0;
  logic [1:0] code = 0;
  int tests = 0, fails = 0, cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  nvm_cmd_status i_nvm_cmd_status (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .launch(launch), .seq_en(seq_en), .ctl_busy(busy),
    .ctl_done(done), .ctl_illegal(ill), .ctl_seq_viol(seqv),
    .ctl_prot_viol(prot), .ctl_err_code(code));

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdata/launch/seq actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", {rdata, launch, seq_en}, {8'h80, 1'b0, 1'b1});
    rst_n = 1;
    @(negedge clk);
    chk("R1", {rdata, launch, seq_en}, {8'h80, 1'b0, 1'b1});
    for (int i = 0; i < NV; i++) begin
      {wr_en, wdata, busy, done, ill, seqv, prot, code} = VEC[i][25:10];
      @(negedge clk);
      wr_en = 0; {busy, done, ill, seqv, prot, code} = '0;
      chk(TAG[i], {rdata, launch, seq_en}, VEC[i][9:0]);
    end
    @(negedge clk);
    chk("R2", {rdata, launch, seq_en}, {8'h80, 1'b0, 1'b1});
    // R8: write to another address is ignored, unselected read is 0
    reg_sel = 3'd5; wr_en = 1; wdata = 8'h80;
    @(negedge clk);
    wr_en = 0;
    chk("R8", {rdata, launch, seq_en}, {8'h00, 1'b0, 1'b1});
    reg_sel = STAT;
    #1 chk("R8", {rdata, launch, seq_en}, {8'h80, 1'b0, 1'b1});
    // R3: flag stays low across several idle cycles until done
    wr_en = 1; wdata = 8'h80;
    @(negedge clk);
    wr_en = 0;
    repeat (3) @(negedge clk);
    chk("R3", {rdata, launch, seq_en}, {8'h00, 1'b0, 1'b0});
    done = 1; code = 2'b10;
    @(negedge clk);
    done = 0; code = 0;
    chk("R3", {rdata, launch, seq_en}, {8'h82, 1'b0, 1'b1});
    // R1: reset mid-state restores defaults
    ill = 1;
    @(negedge clk);
    ill = 0;
    rst_n = 0;
    #1 chk("R1", {rdata, launch, seq_en}, {8'h80, 1'b0, 1'b1});
    @(negedge clk);
    finish_run();
  end
endmodule